// File: doc/BRIEF.md
# Four-Channel Compare System Timer

This block keeps a 64-bit free-running count that advances by one on each cycle where the tick-enable input is high. Four compare channels each hold a 32-bit target value. On every tick cycle, each target is compared against the low 32 bits of the count. When a channel sees an equal value, it latches a pending flag. That flag drives the channel's own interrupt line toward an interrupt controller.

Software reaches the block through a small word-addressed register window. The window has one status/control word, the two halves of the count and the four compare targets. A pending flag stays set until software writes a one to its bit in the status/control word. Writing a zero to a bit leaves it alone. The count is read-only.

The match is evaluated against the count value held during the tick cycle, before that cycle's increment. A compare write lands at the clock edge, so the new target first takes part in the comparison on the next tick. If the count already equals the new target on that tick, the channel fires.

Top module: `sys_timer`

## Requirements
- R1: After reset, the count, all four compare targets, all pending flags and all interrupt lines are zero.
- R2: The count increases by exactly one after each clock edge at which tick_en is high, modulo 2^64, and holds when tick_en is low.
- R3: At a clock edge with tick_en high where the low 32 bits of the count equal compare target i, pending flag i is set after that edge.
- R4: A match on one channel sets only that channel's pending flag. The other channels are unaffected.
- R5: irq[i] always equals pending flag i.
- R6: A pending flag stays set across any number of cycles until it is cleared by software.
- R7: A write to byte address 0x00 clears pending flag i for each wdata bit i that is 1 (bits 3:0). Zero bits have no effect. If a match sets the same flag in the same cycle, the set wins.
- R8: A compare write takes effect at the clock edge of the write cycle. A tick in that same cycle still compares against the old target. The next tick uses the new target and fires if the count equals it.
- R9: The read data is combinational from the address:
  - 0x00 returns the pending flags in bits 3:0, with zeros above them.
  - 0x04 returns count bits 31:0.
  - 0x08 returns count bits 63:32.
  - 0x0C + 4*i returns compare target i.
- R10: Writes to 0x04 and 0x08 are ignored. Any address with nonzero bits 1:0, or beyond 0x18, reads as zero and ignores writes.
- R11: While tick_en is low, no pending flag becomes set, even if a compare target equals the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count advance and compare enable for this cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq | output | 4 | Per-channel interrupt level |

## Verification
The bench goes after the following corner cases, each of which a faulty design would get wrong in a visible way.

- **First tick after reset.** All targets equal the zero count, so all four channels must fire together. A design that masked matches until a target had been written would miss this.
- **Clear and match in the same cycle.** The set must win. A design that gave the clear priority would lose an interrupt.
- **Compare write and tick in the same cycle.** The tick must compare against the old target. A design that bypassed the write data into the comparator would fire one tick early.
- **Equal target with the count stopped.** No flag may be raised. A level-compare design would fire without any tick.
- **Stray writes.** Writes to the count, misaligned addresses and writes of zero bits to the status word must change nothing. The bench checks this by reading back every register.

// File: rtl/st_pkg.sv
package st_pkg;
    localparam int DATA_W     = 32;
    // word indices inside the register window
    localparam int IDX_CTRL   = 0;
    localparam int IDX_CNT_LO = 1;
    localparam int IDX_CNT_HI = 2;
    localparam int IDX_CMP0   = 3;

    function automatic int map_words(input int n_ch);
        return IDX_CMP0 + n_ch;
    endfunction
endpackage

// File: rtl/st_counter.sv
module st_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/st_channel.sv
module st_channel #(
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CMP_W-1:0] cnt_lo,
    input  logic             cmp_we,
    input  logic [CMP_W-1:0] cmp_wdata,
    input  logic             clr,
    output logic [CMP_W-1:0] cmp_q,
    output logic             pend_q
);
    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        logic             pend;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        st_d = st_q;
        // compare uses the target held during this cycle
        hit  = tick && (cnt_lo == st_q.cmp);
        if (cmp_we) st_d.cmp = cmp_wdata;
        // a match outranks a software clear
        st_d.pend = hit | (st_q.pend & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_q  = st_q.cmp;
    assign pend_q = st_q.pend;

    p_match_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_lo == cmp_q) |=> pend_q);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr) |=> pend_q);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && clr && !(tick && cnt_lo == cmp_q)) |=> !pend_q);
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !tick) |=> !pend_q);
    p_cmp_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> cmp_q == $past(cmp_wdata));
endmodule

// File: rtl/st_regdec.sv
module st_regdec
    import st_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int CNT_W = 64,
    parameter int AW    = 5
) (
    input  logic                   wr_en,
    input  logic [AW-1:0]          addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [N_CH-1:0]        pend,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [N_CH*DATA_W-1:0] cmp_flat,
    output logic [N_CH-1:0]        clr,
    output logic [N_CH-1:0]        cmp_we,
    output logic [DATA_W-1:0]      rdata
);
    localparam int WIW = AW - 2;

    logic           aligned;
    logic [WIW-1:0] widx;

    assign aligned = (addr[1:0] == 2'b00);
    assign widx    = addr[AW-1:2];

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (widx == WIW'(IDX_CTRL))   rdata = DATA_W'(pend);
            if (widx == WIW'(IDX_CNT_LO)) rdata = cnt[DATA_W-1:0];
            if (widx == WIW'(IDX_CNT_HI)) rdata = DATA_W'(cnt >> DATA_W);
            for (int i = 0; i < N_CH; i++) begin
                if (widx == WIW'(IDX_CMP0 + i)) rdata = cmp_flat[i*DATA_W +: DATA_W];
            end
        end
    end

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_strobe
            assign clr[g]    = wr_en && aligned && (widx == WIW'(IDX_CTRL)) && wdata[g];
            assign cmp_we[g] = wr_en && aligned && (widx == WIW'(IDX_CMP0 + g));
        end
    endgenerate
endmodule

// File: rtl/sys_timer.sv
module sys_timer
    import st_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int CNT_W = 64,
    parameter int AW    = $clog2(map_words(N_CH) * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_CH-1:0]   irq
);
    logic [CNT_W-1:0]       cnt_q;
    logic [N_CH-1:0]        pend;
    logic [N_CH-1:0]        clr;
    logic [N_CH-1:0]        cmp_we;
    logic [N_CH*DATA_W-1:0] cmp_flat;

    st_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .cnt_q(cnt_q)
    );

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            st_channel #(.CMP_W(DATA_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick_en),
                .cnt_lo   (cnt_q[DATA_W-1:0]),
                .cmp_we   (cmp_we[g]),
                .cmp_wdata(wdata),
                .clr      (clr[g]),
                .cmp_q    (cmp_flat[g*DATA_W +: DATA_W]),
                .pend_q   (pend[g])
            );
        end
    endgenerate

    st_regdec #(.N_CH(N_CH), .CNT_W(CNT_W), .AW(AW)) u_dec (
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .pend(pend),
        .cnt(cnt_q), .cmp_flat(cmp_flat),
        .clr(clr), .cmp_we(cmp_we), .rdata(rdata)
    );

    assign irq = pend;

    p_status_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(0)) |-> (rdata == DATA_W'(irq)));
    p_cnt_lo_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(IDX_CNT_LO * 4)) |-> (rdata == cnt_q[DATA_W-1:0]));
    p_misaligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] != 2'b00) |-> (rdata == '0));
endmodule

// File: tb/sim_sys_timer.sv
module sim_sys_timer;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int n_vec = 0;
    int n_bad = 0;

    logic [63:0] m_cnt;
    logic [31:0] m_cmp [4];
    logic [3:0]  m_st;

    sys_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        #0.4;
        v = rdata;
    endtask

    task automatic check_regs(input string req);
        logic [31:0] v;
        rd(5'd0, v);  chk({req, " R9 status"}, 64'(v), 64'(m_st));
        rd(5'd4, v);  chk({req, " R9 cnt_lo"}, 64'(v), 64'(m_cnt[31:0]));
        rd(5'd8, v);  chk({req, " R9 cnt_hi"}, 64'(v), 64'(m_cnt[63:32]));
        for (int i = 0; i < 4; i++) begin
            rd(5'(12 + 4 * i), v);
            chk({req, " R9 cmp"}, 64'(v), 64'(m_cmp[i]));
        end
    endtask

    // one clock: drive at negedge, update model at posedge, check at next negedge
    task automatic step(input bit tk, input bit we, input logic [4:0] a,
                        input logic [31:0] d, input string req);
        logic [3:0] set_v;
        logic [3:0] clr_v;
        tick_en = tk; wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        set_v = '0;
        if (tk) for (int i = 0; i < 4; i++) set_v[i] = (m_cmp[i] == m_cnt[31:0]);
        clr_v = (we && a == 5'd0) ? d[3:0] : 4'd0;
        m_st = (m_st & ~clr_v) | set_v;
        if (we && a[1:0] == 2'b00 && a >= 5'd12 && a <= 5'd24) m_cmp[(int'(a) - 12) / 4] = d;
        if (tk) m_cnt = m_cnt + 64'd1;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        chk({req, " R5 irq"}, 64'(irq), 64'(m_st));
        check_regs(req);
    endtask

    initial begin
        #(8ns * 200000);
        n_bad++;
        $display("FAIL watchdog expired, run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        m_cnt = '0; m_st = '0;
        for (int i = 0; i < 4; i++) m_cmp[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_regs("R1");
        chk("R1 irq", 64'(irq), 64'd0);

        // R2, R3: first tick hits all zero targets, then mixed tick pattern
        for (int k = 0; k < 24; k++) step(k % 3 != 2, 1'b0, 5'd0, 32'd0, "R2 R3");
        step(1'b0, 1'b1, 5'd0, 32'hF, "R7");

        // R10: stray writes and unmapped reads
        step(1'b0, 1'b1, 5'd4, 32'hDEAD_BEEF, "R10");
        step(1'b0, 1'b1, 5'd8, 32'h1234_5678, "R10");
        step(1'b1, 1'b1, 5'd13, 32'hFFFF_FFFF, "R10");
        rd(5'd28, v); chk("R10 unmapped", 64'(v), 64'd0);
        rd(5'd5, v);  chk("R10 misaligned", 64'(v), 64'd0);

        // R3, R4, R8: per-channel sweep of target offsets
        for (int ch = 0; ch < 4; ch++) begin
            for (int off = 0; off < 5; off++) begin
                step(1'b0, 1'b1, 5'(12 + 4 * ch), m_cnt[31:0] + 32'(off), "R8");
                for (int t = 0; t < 6; t++) step(1'b1, 1'b0, 5'd0, 32'd0, "R3 R4");
                step(1'b0, 1'b1, 5'd0, 32'hF, "R7");
            end
        end

        // R6: sticky across idle and ticking cycles
        step(1'b0, 1'b1, 5'd12, m_cnt[31:0], "R6");
        step(1'b1, 1'b0, 5'd0, 32'd0, "R6");
        for (int k = 0; k < 8; k++) step(k[0], 1'b0, 5'd0, 32'd0, "R6");

        // R7: zero bits and other bits leave flag 0, one clears, set wins over clear
        step(1'b0, 1'b1, 5'd0, 32'h0, "R7");
        step(1'b0, 1'b1, 5'd0, 32'hE, "R7");
        step(1'b0, 1'b1, 5'd0, 32'h1, "R7");
        step(1'b0, 1'b1, 5'd16, m_cnt[31:0], "R7");
        step(1'b1, 1'b1, 5'd0, 32'h2, "R7");
        step(1'b0, 1'b1, 5'd0, 32'h2, "R7");

        // R8: write and tick in the same cycle compares against the old target
        step(1'b1, 1'b1, 5'd20, m_cnt[31:0], "R8");
        step(1'b1, 1'b1, 5'd20, m_cnt[31:0] + 32'd1, "R8");
        step(1'b1, 1'b0, 5'd0, 32'd0, "R8");
        step(1'b0, 1'b1, 5'd0, 32'hF, "R8");

        // R11: equal target while stopped does not fire
        step(1'b0, 1'b1, 5'd24, m_cnt[31:0], "R11");
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 5'd0, 32'd0, "R11");
        step(1'b1, 1'b0, 5'd0, 32'd0, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule